// File: doc/BRIEF.md
# GPIO Change-Detect Interrupt Controller

This block collects interrupt events from a bank of general-purpose input lines and reports them to a parent interrupt controller over one summary wire. Every line is first brought into the local clock domain by a chain of synchronizer flops. A one-cycle comparison then spots any toggle, whether the line rises or falls. Each toggle sets a sticky per-line pending flag. There is no choice between edge and level sensing: every transition counts.

Software unmasks lines in an enable register. It reads an identity register to find which enabled lines need service, and acknowledges a line by writing a one to its bit in the pending register. When a source holds its line at an active level until it is serviced, software acknowledges only after the line has gone back to idle. This way the return transition does not leave a stale event behind. The bus is a plain single-cycle register port. Read data arrives on the clock edge after the request, or in the same cycle in the combinational read variant.

Top module: `gpio_toggle_intc`

## Requirements
- R1: A change of a line in either direction sets that line's pending bit. With SYNC_STAGES synchronizer flops, the bit is set on the (SYNC_STAGES+1)-th rising edge after the first edge that samples the new level.
- R2: The enable register sits at byte offset 0x0. It resets to all zeros, so every line is masked. A write loads bus_wdata into it, and a read returns the value written.
- R3: The pending register sits at offset 0x4. Writing a 1 to a bit clears that bit. Writing a 0 leaves that bit unchanged.
- R4: The identity register sits at offset 0x8 and reads pending AND enable, bit by bit. Masking a line hides its pending bit from the identity register without clearing the pending bit.
- R5: irq_out is a registered OR of the identity bits. It rises one edge after an enabled pending bit becomes 1, and it falls one edge after the last such bit clears.
- R6: Offset 0xC reads the synchronized level of every line. Bit n is line n.
- R7: If a line toggles in the same cycle as a write-one-to-clear of its bit, the pending bit stays 1. Bits in the same write whose lines did not toggle are cleared.
- R8: After reset, pending is zero and irq_out is low. Levels already present on the lines while reset is asserted do not create events once reset is released.
- R9: Writes to offsets 0x8 and 0xC, and writes to unmapped offsets, change no register. A read from an unmapped offset returns zero.
- R10: With RDATA_REG=1, bus_rdata takes the addressed value on the edge that accepts the read and holds it until the next read.
- R11: If a line held high is acknowledged while still high, its return to low sets pending again. If it is acknowledged after it has returned low, it stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NLINES | Asynchronous input lines |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | NLINES | Write data |
| bus_rdata | output | NLINES | Read data |
| irq_out | output | 1 | Summary interrupt to the parent controller |

## Verification
The bench builds the block with NLINES=8, SYNC_STAGES=2 and RDATA_REG=1. Eight lines are few enough to drive distinct bit patterns, rising and falling, across the whole bank, and to check exact register values.

Two synchronizer stages fix the edge at which irq_out must rise, so latency is checked to the cycle. The same fixed count lets the bench line up a toggle with a clear write in one exact cycle to exercise the set-wins rule. The registered read path is the one exercised, including that read data holds between reads.

// File: rtl/gti_pkg.sv
package gti_pkg;

   localparam int unsigned GTI_OFS_ENABLE  = 32'h0;
   localparam int unsigned GTI_OFS_PENDING = 32'h4;
   localparam int unsigned GTI_OFS_IDENT   = 32'h8;
   localparam int unsigned GTI_OFS_RAW     = 32'hC;

   typedef enum logic [1:0] {
      GTI_SEL_ENABLE,
      GTI_SEL_PENDING,
      GTI_SEL_IDENT,
      GTI_SEL_RAW
   } gti_sel_e;

   typedef struct packed {
      logic     hit;
      gti_sel_e sel;
   } gti_dec_t;

   // Map a byte address onto a register select; hit is low for holes.
   function automatic gti_dec_t gti_decode(input logic [31:0] addr);
      gti_dec_t d;
      d.hit = 1'b1;
      d.sel = GTI_SEL_ENABLE;
      case (addr)
         GTI_OFS_ENABLE:  d.sel = GTI_SEL_ENABLE;
         GTI_OFS_PENDING: d.sel = GTI_SEL_PENDING;
         GTI_OFS_IDENT:   d.sel = GTI_SEL_IDENT;
         GTI_OFS_RAW:     d.sel = GTI_SEL_RAW;
         default:         d.hit = 1'b0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/gti_sync.sv
module gti_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gti_change.sv
module gti_change #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned SETTLE = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   output logic [WIDTH-1:0] toggled,
   output logic             armed
);

   localparam int unsigned CNT_W = $clog2(SETTLE + 1) + 1;
   localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(SETTLE);

   logic [WIDTH-1:0] level_q;
   logic [CNT_W-1:0] settle_cnt;

   // The previous level follows the input from the first edge on, so no
   // stale reset value is compared once the detector is armed.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= '0;
      else        level_q <= level;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   settle_cnt <= '0;
      else if (settle_cnt != CNT_DONE) settle_cnt <= settle_cnt + 1'b1;
   end

   assign armed   = (settle_cnt == CNT_DONE);
   assign toggled = armed ? (level ^ level_q) : '0;

endmodule

// File: rtl/gti_regfile.sv
module gti_regfile
   import gti_pkg::*;
#(
   parameter int unsigned WIDTH     = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter bit          RDATA_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  toggled,
   input  logic [WIDTH-1:0]  level,
   output logic [WIDTH-1:0]  enable_q,
   output logic [WIDTH-1:0]  pending_q,
   output logic              irq_q
);

   gti_dec_t         dec;
   logic             wr_acc;
   logic             rd_acc;
   logic [WIDTH-1:0] clr_mask;
   logic [WIDTH-1:0] ident;
   logic [WIDTH-1:0] rd_val;

   assign dec    = gti_decode(32'(bus_addr));
   assign wr_acc = bus_en & bus_we;
   assign rd_acc = bus_en & ~bus_we;

   assign clr_mask = (wr_acc && dec.hit && dec.sel == GTI_SEL_PENDING) ? bus_wdata : '0;
   assign ident    = pending_q & enable_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         enable_q <= '0;
      else if (wr_acc && dec.hit && dec.sel == GTI_SEL_ENABLE)
         enable_q <= bus_wdata;
   end

   // A toggle in the clearing cycle wins over the acknowledge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending_q <= '0;
      else        pending_q <= (pending_q & ~clr_mask) | toggled;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |ident;
   end

   always_comb begin
      rd_val = '0;
      if (dec.hit) begin
         case (dec.sel)
            GTI_SEL_ENABLE:  rd_val = enable_q;
            GTI_SEL_PENDING: rd_val = pending_q;
            GTI_SEL_IDENT:   rd_val = ident;
            GTI_SEL_RAW:     rd_val = level;
            default:         rd_val = '0;
         endcase
      end
   end

   if (RDATA_REG) begin : g_rd_reg
      logic [WIDTH-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      rdata_q <= '0;
         else if (rd_acc) rdata_q <= rd_val;
      end
      assign bus_rdata = rdata_q;
   end else begin : g_rd_comb
      assign bus_rdata = rd_val;
   end

endmodule

// File: rtl/gpio_toggle_intc.sv
module gpio_toggle_intc #(
   parameter int unsigned NLINES      = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 4,
   parameter bit          RDATA_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] line_in,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [NLINES-1:0] bus_wdata,
   output logic [NLINES-1:0] bus_rdata,
   output logic              irq_out
);

   localparam int unsigned SETTLE = SYNC_STAGES + 1;

   if (NLINES < 1 || NLINES > 32) begin : g_bad_lines
      $error("gpio_toggle_intc: NLINES must lie in 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_toggle_intc: SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_addr
      $error("gpio_toggle_intc: ADDR_W must lie in 4..32");
   end

   logic [NLINES-1:0] line_sync;
   logic [NLINES-1:0] toggled;
   logic              armed;
   logic [NLINES-1:0] enable_q;
   logic [NLINES-1:0] pending_q;

   gti_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (line_in),
      .sync_out (line_sync)
   );

   gti_change #(.WIDTH(NLINES), .SETTLE(SETTLE)) u_change (
      .clk     (clk),
      .rst_n   (rst_n),
      .level   (line_sync),
      .toggled (toggled),
      .armed   (armed)
   );

   gti_regfile #(.WIDTH(NLINES), .ADDR_W(ADDR_W), .RDATA_REG(RDATA_REG)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .toggled   (toggled),
      .level     (line_sync),
      .enable_q  (enable_q),
      .pending_q (pending_q),
      .irq_q     (irq_out)
   );

endmodule

// File: rtl/gti_checker.sv
module gti_checker #(
   parameter int unsigned NLINES = 32,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              armed,
   input logic [NLINES-1:0] line_sync,
   input logic [NLINES-1:0] toggled,
   input logic [NLINES-1:0] pending_q,
   input logic [NLINES-1:0] enable_q,
   input logic              bus_en,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [NLINES-1:0] bus_wdata,
   input logic              irq_out
);

   logic [NLINES-1:0] seen_q;
   logic              clr_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= '0;
      else        seen_q <= line_sync;
   end

   assign clr_wr = bus_en && bus_we && (32'(bus_addr) == 32'h4);

   AST_TOGGLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && (line_sync != seen_q)) |=>
         ((pending_q & $past(line_sync ^ seen_q)) == $past(line_sync ^ seen_q))); // R1

   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> (($past(pending_q) & ~pending_q) == '0)); // R3

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((pending_q & $past(bus_wdata & ~toggled)) == '0)); // R3

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && (toggled != '0)) |=> ((pending_q & $past(toggled)) == $past(toggled))); // R7

   AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pending_q & enable_q)) |=> irq_out); // R5

   AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(pending_q & enable_q)) |=> !irq_out); // R5

   AST_QUIET_START: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (pending_q == '0 && !irq_out)); // R8

endmodule

bind gpio_toggle_intc gti_checker #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .armed     (armed),
   .line_sync (line_sync),
   .toggled   (toggled),
   .pending_q (pending_q),
   .enable_q  (enable_q),
   .bus_en    (bus_en),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq_out   (irq_out)
);

// File: tb/sim_gpio_toggle_intc.sv
`timescale 1ns/1ps
module sim_gpio_toggle_intc;

   localparam int unsigned NL = 8;
   localparam int unsigned AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] line_in = '0;
   logic          bus_en = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [NL-1:0] bus_wdata = '0;
   logic [NL-1:0] bus_rdata;
   logic          irq_out;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_toggle_intc #(.NLINES(NL), .SYNC_STAGES(2), .ADDR_W(AW), .RDATA_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .line_in(line_in),
      .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [NL-1:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_en = 1'b0;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [NL-1:0] v;
      line_in = 8'hA5;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      settle();
      chk("R8 irq after reset", 32'(irq_out), 32'h0);
      rd(4'h4, v); chk("R8 pending after reset with lines high", 32'(v), 32'h0);
      rd(4'h0, v); chk("R2 enable reset value", 32'(v), 32'h0);
      rd(4'hC, v); chk("R6 raw level", 32'(v), 32'hA5);
   endtask

   task automatic t_regs();
      logic [NL-1:0] v;
      wr(4'h0, 8'h3C);
      rd(4'h0, v); chk("R2 enable readback", 32'(v), 32'h3C);
      repeat (3) @(negedge clk);
      chk("R10 rdata held between reads", 32'(bus_rdata), 32'h3C);
      wr(4'h8, 8'hFF);
      wr(4'hC, 8'hFF);
      wr(4'h2, 8'hFF);
      rd(4'h0, v); chk("R9 ignored writes keep enable", 32'(v), 32'h3C);
      rd(4'h4, v); chk("R9 ignored writes keep pending", 32'(v), 32'h0);
      rd(4'h6, v); chk("R9 unmapped read is zero", 32'(v), 32'h0);
      wr(4'h0, 8'h00);
   endtask

   task automatic t_latency();
      logic [NL-1:0] v;
      line_in = 8'h00;
      settle();
      wr(4'h4, 8'hFF);
      wr(4'h0, 8'h01);
      // rising edge of line 0
      @(negedge clk); line_in[0] = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk); chk("R5 irq not yet on third edge", 32'(irq_out), 32'h0);
      @(posedge clk);
      @(negedge clk); chk("R1 R5 irq on fourth edge after rise", 32'(irq_out), 32'h1);
      rd(4'h8, v); chk("R4 identity after rise", 32'(v), 32'h01);
      wr(4'h4, 8'h01);
      @(negedge clk); chk("R5 irq drops after clear", 32'(irq_out), 32'h0);
      // falling edge of line 0
      @(negedge clk); line_in[0] = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); chk("R5 irq not yet after fall", 32'(irq_out), 32'h0);
      @(posedge clk);
      @(negedge clk); chk("R1 irq on fourth edge after fall", 32'(irq_out), 32'h1);
      wr(4'h4, 8'hFF);
      wr(4'h0, 8'h00);
   endtask

   task automatic t_w1c_mask();
      logic [NL-1:0] v;
      line_in = 8'h5A;
      settle();
      rd(4'h4, v); chk("R1 pattern sets pending", 32'(v), 32'h5A);
      rd(4'hC, v); chk("R6 raw follows pattern", 32'(v), 32'h5A);
      chk("R4 masked lines keep irq low", 32'(irq_out), 32'h0);
      rd(4'h8, v); chk("R4 identity zero when masked", 32'(v), 32'h00);
      wr(4'h0, 8'h0F);
      rd(4'h8, v); chk("R4 identity is pending and enable", 32'(v), 32'h0A);
      wr(4'h4, 8'h00);
      rd(4'h4, v); chk("R3 writing zero keeps pending", 32'(v), 32'h5A);
      wr(4'h4, 8'h12);
      rd(4'h4, v); chk("R3 one clears bit", 32'(v), 32'h48);
      wr(4'h0, 8'h00);
      rd(4'h4, v); chk("R4 masking keeps pending", 32'(v), 32'h48);
      line_in = 8'h00;
      settle();
      wr(4'h4, 8'hFF);
      rd(4'h4, v); chk("R3 clear all", 32'(v), 32'h00);
   endtask

   task automatic t_set_wins();
      logic [NL-1:0] v;
      line_in = 8'h06;
      settle();
      // bits 1 and 2 now pending; toggle line 1 timed with a clear of 1 and 2
      @(negedge clk); line_in[1] = 1'b0;
      @(posedge clk);
      @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = 4'h4; bus_wdata = 8'h06;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
      rd(4'h4, v); chk("R7 toggle wins over clear", 32'(v), 32'h02);
      line_in = 8'h00;
      settle();
      wr(4'h4, 8'hFF);
   endtask

   task automatic t_level();
      logic [NL-1:0] v;
      wr(4'h0, 8'h08);
      line_in[3] = 1'b1;
      settle();
      chk("R11 irq while held", 32'(irq_out), 32'h1);
      wr(4'h4, 8'h08);
      rd(4'h4, v); chk("R11 early ack clears", 32'(v), 32'h00);
      line_in[3] = 1'b0;
      settle();
      rd(4'h4, v); chk("R11 release after early ack is stale event", 32'(v), 32'h08);
      wr(4'h4, 8'h08);
      line_in[3] = 1'b1;
      settle();
      line_in[3] = 1'b0;
      settle();
      wr(4'h4, 8'h08);
      settle();
      rd(4'h4, v); chk("R11 ack after release stays clear", 32'(v), 32'h00);
      chk("R11 irq low after late ack", 32'(irq_out), 32'h0);
      wr(4'h0, 8'h00);
   endtask

   initial begin
      t_reset();
      t_regs();
      t_latency();
      t_w1c_mask();
      t_set_wins();
      t_level();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule